// File: doc/BRIEF.md
# SD/MMC Command and Response Engine

This block drives the command line of an SD/MMC host. Software places a 32-bit argument and a 6-bit command index on its inputs. It then pulses `start` together with a 5-bit step mask. The engine runs every selected step in a fixed order, then goes idle:

1. a 74-clock idle burst,
2. the 48-bit command frame with its CRC7,
3. the search for and capture of a 48-bit or 136-bit response,
4. an 8-clock idle burst.

Each selected step shows as a pending bit that clears itself when that step ends. Software polls these bits in the same way it would poll self-clearing enable bits.

The engine moves one card bit per core clock cycle. `card_clk_en` marks each cycle in which a card clock edge is issued, and clock division is left to the surroundings. Received responses are checked with CRC7 and the result is reported. A mismatch latches a flag that software clears, even for response types whose CRC field carries no meaning. A response that never starts raises a timeout flag. The DAT0 level is mirrored so that software can poll for card busy. A controller-reset input aborts whatever is in progress.

Top module: `sdcmd_engine`

## Requirements
- R1: `start` loads `step_en` into `step_pend` only when `step_pend` is all zero and `ctl_reset` is low; a `start` while any step is pending changes nothing. The step bits are: bit 0 send command, bit 1 short (48-bit) response, bit 2 long (136-bit) response, bit 3 74-clock burst, bit 4 8-clock burst.
- R2: The command step drives `cmd_oe` high for exactly 48 cycles, MSB first: `0`, `1`, index[5:0], argument[31:0], CRC7 over the first 40 bits (polynomial x^7+x^3+1, register starting at zero), then `1`. Its pending bit clears after the last bit.
- R3: A response step samples `cmd_i` each clocked cycle until it reads 0. It then takes the rest of the frame (48 bits in total for short, 136 for long; long wins if both bits are set) and clears both response bits. A long response stores the last 128 frame bits into `resp`, with the end bit at bit 0. A short response stores index in `resp[37:32]` and argument in `resp[31:0]`, with the upper bits zero.
- R4: After each response `crc_ok` is 1 if the received CRC7 equals the one computed. This covers frame bits 0..39 for short and bits 8..127 for long. On a mismatch `crc_flag` is set and stays set until a `crc_clr` pulse. A set in the same cycle wins over a clear. The check is never suppressed, so a response with a meaningless CRC field still raises the flag and still updates `resp`.
- R5: If no start bit arrives within 64 clocked cycles, `tout_flag` is set and both response bits clear. `resp` is left unchanged. `tout_clr` clears the flag.
- R6: The 74-clock and 8-clock steps issue exactly 74 and 8 clocked cycles with `cmd_o` high and `cmd_oe` low. `cmd_o` is high whenever `cmd_oe` is low.
- R7: Steps run in the order 74-clock, command, response, 8-clock. Each step is preceded by one cycle without a card clock. The total number of clocked cycles is the sum over the selected steps.
- R8: `ctl_reset` clears every pending bit and stops the card clock from the next cycle on.
- R9: `dat0_level` equals `dat0_i` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_reset | input | 1 | Synchronous engine abort |
| start | input | 1 | Launch the steps in `step_en` |
| step_en | input | 5 | Step selection mask |
| cmd_index | input | 6 | Command index for the frame |
| cmd_arg | input | 32 | Command argument |
| crc_clr | input | 1 | Clears `crc_flag` |
| tout_clr | input | 1 | Clears `tout_flag` |
| cmd_i | input | 1 | CMD line level from the card |
| dat0_i | input | 1 | DAT0 line level from the card |
| step_pend | output | 5 | Self-clearing pending steps |
| cmd_o | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| card_clk_en | output | 1 | A card clock is issued this cycle |
| resp | output | 128 | Captured response |
| crc_ok | output | 1 | Last response CRC7 matched |
| crc_flag | output | 1 | Sticky CRC mismatch flag |
| tout_flag | output | 1 | Sticky response timeout flag |
| dat0_level | output | 1 | Registered DAT0 level (1 = not busy) |

## Verification
The step mask lands in `step_pend` one cycle after `start`. Every step then begins after one cycle with no card clock. A command bit shows on `cmd_o` in the same cycle that it is clocked. A response bit driven in a cycle with `card_clk_en` high is taken at the edge that ends that cycle. `resp`, `crc_ok` and the flags change at the edge that takes the end bit or the 64th idle bit. That is the same edge at which the response bits clear, and `dat0_level` follows its input one edge later. The bench drives stimulus on falling edges and samples on the next falling edge. It counts clocked cycles and total cycles until `step_pend` reads zero, and compares these with the sum computed for the selected mask. Status and flags are read only once the pending bits have cleared.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam int IDX_W      = 6;
    localparam int ARG_W      = 32;
    localparam int CMD_BITS   = IDX_W + ARG_W + 10;
    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int RESP_W     = 128;
    localparam int STEP_N     = 5;

    // step mask bit positions
    localparam int S_CMD   = 0;
    localparam int S_SHORT = 1;
    localparam int S_LONG  = 2;
    localparam int S_CLK74 = 3;
    localparam int S_CLK8  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BURST_L,
        ST_SEND,
        ST_HUNT,
        ST_RECV,
        ST_BURST_S
    } eng_st_e;

    // one serial step of CRC7, x^7 + x^3 + 1
    function automatic logic [6:0] crc7_step(logic [6:0] c, logic b);
        logic fb;
        fb = c[6] ^ b;
        return {c[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
    endfunction
endpackage

// File: rtl/sdcmd_crc7_par.sv
module sdcmd_crc7_par
    import sdcmd_pkg::*;
#(
    parameter int W = 40
) (
    input  logic [W-1:0] data,
    output logic [6:0]   crc
);
    always_comb begin
        logic [6:0] acc;
        acc = '0;
        for (int i = W - 1; i >= 0; i--) begin
            acc = crc7_step(acc, data[i]);
        end
        crc = acc;
    end
endmodule

// File: rtl/sdcmd_crc7_ser.sv
module sdcmd_crc7_ser
    import sdcmd_pkg::*;
(
    input  logic [6:0] crc_in,
    input  logic       bit_i,
    input  logic       en,
    output logic [6:0] crc_out
);
    assign crc_out = en ? crc7_step(crc_in, bit_i) : crc_in;
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int LONG_BURST  = 74,
    parameter int SHORT_BURST = 8,
    parameter int HUNT_LIMIT  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_reset,
    input  logic              start,
    input  logic [STEP_N-1:0] step_en,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic              crc_clr,
    input  logic              tout_clr,
    input  logic              cmd_i,
    input  logic              dat0_i,
    output logic [STEP_N-1:0] step_pend,
    output logic              cmd_o,
    output logic              cmd_oe,
    output logic              card_clk_en,
    output logic [RESP_W-1:0] resp,
    output logic              crc_ok,
    output logic              crc_flag,
    output logic              tout_flag,
    output logic              dat0_level
);
    localparam int MAX_A   = (LONG_BITS > LONG_BURST) ? LONG_BITS : LONG_BURST;
    localparam int CNT_MAX = (MAX_A > HUNT_LIMIT) ? MAX_A : HUNT_LIMIT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int RX_W    = RESP_W - 1;
    localparam int BODY_W  = CMD_BITS - 8;
    localparam int PAY_W   = IDX_W + ARG_W;

    localparam logic [CNT_W-1:0] L_BURST_LAST = CNT_W'(LONG_BURST - 1);
    localparam logic [CNT_W-1:0] S_BURST_LAST = CNT_W'(SHORT_BURST - 1);
    localparam logic [CNT_W-1:0] SEND_LAST    = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] HUNT_LAST    = CNT_W'(HUNT_LIMIT - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST   = CNT_W'(SHORT_BITS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST    = CNT_W'(LONG_BITS - 1);
    localparam logic [CNT_W-1:0] SHORT_CRC_HI = CNT_W'(SHORT_BITS - 8);
    localparam logic [CNT_W-1:0] LONG_CRC_LO  = CNT_W'(LONG_BITS - RESP_W);
    localparam logic [CNT_W-1:0] LONG_CRC_HI  = CNT_W'(LONG_BITS - 8);

    typedef struct packed {
        eng_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic [STEP_N-1:0]   pend;
        logic [CMD_BITS-1:0] tx;
        logic [RX_W-1:0]     rx;
        logic [6:0]          crc;
        logic [RESP_W-1:0]   resp;
        logic                crc_ok;
        logic                crc_flag;
        logic                tout_flag;
        logic                dat0;
    } eng_s;

    eng_s q, d;

    logic [BODY_W-1:0] tx_body;
    logic [6:0]        tx_crc;
    logic [RESP_W-1:0] rx_full;
    logic [CNT_W-1:0]  pos;
    logic              use_long;
    logic              in_crc;
    logic [6:0]        crc_upd;

    assign tx_body  = {1'b0, 1'b1, cmd_index, cmd_arg};
    assign rx_full  = {q.rx, cmd_i};
    assign use_long = q.pend[S_LONG];
    assign pos      = (q.st == ST_HUNT) ? '0 : q.cnt;
    assign in_crc   = use_long ? (pos >= LONG_CRC_LO && pos < LONG_CRC_HI)
                               : (pos < SHORT_CRC_HI);

    sdcmd_crc7_par #(.W(BODY_W)) u_txcrc (
        .data (tx_body),
        .crc  (tx_crc)
    );

    sdcmd_crc7_ser u_rxcrc (
        .crc_in  (q.crc),
        .bit_i   (cmd_i),
        .en      (in_crc),
        .crc_out (crc_upd)
    );

    always_comb begin
        d = q;
        d.dat0 = dat0_i;
        if (crc_clr)  d.crc_flag  = 1'b0;
        if (tout_clr) d.tout_flag = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                d.cnt = '0;
                d.crc = '0;
                if (q.pend[S_CLK74])                        d.st = ST_BURST_L;
                else if (q.pend[S_CMD])                     d.st = ST_SEND;
                else if (q.pend[S_LONG] | q.pend[S_SHORT])  d.st = ST_HUNT;
                else if (q.pend[S_CLK8])                    d.st = ST_BURST_S;
                if (start && q.pend == '0) begin
                    d.pend = step_en;
                    d.tx   = {tx_body, tx_crc, 1'b1};
                end
            end
            ST_BURST_L: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == L_BURST_LAST) begin
                    d.pend[S_CLK74] = 1'b0;
                    d.st = ST_IDLE;
                end
            end
            ST_SEND: begin
                d.cnt = q.cnt + 1'b1;
                d.tx  = {q.tx[CMD_BITS-2:0], 1'b0};
                if (q.cnt == SEND_LAST) begin
                    d.pend[S_CMD] = 1'b0;
                    d.st = ST_IDLE;
                end
            end
            ST_HUNT: begin
                if (!cmd_i) begin
                    d.rx  = rx_full[RX_W-1:0];
                    d.crc = crc_upd;
                    d.cnt = CNT_W'(1);
                    d.st  = ST_RECV;
                end else if (q.cnt == HUNT_LAST) begin
                    d.tout_flag      = 1'b1;
                    d.pend[S_SHORT]  = 1'b0;
                    d.pend[S_LONG]   = 1'b0;
                    d.st = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RECV: begin
                d.rx  = rx_full[RX_W-1:0];
                d.crc = crc_upd;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == (use_long ? LONG_LAST : SHORT_LAST)) begin
                    d.crc_ok = (q.crc == rx_full[7:1]);
                    if (q.crc != rx_full[7:1]) d.crc_flag = 1'b1;
                    d.resp = use_long ? rx_full
                                      : {{(RESP_W-PAY_W){1'b0}}, rx_full[SHORT_BITS-3 -: PAY_W]};
                    d.pend[S_SHORT] = 1'b0;
                    d.pend[S_LONG]  = 1'b0;
                    d.st = ST_IDLE;
                end
            end
            ST_BURST_S: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == S_BURST_LAST) begin
                    d.pend[S_CLK8] = 1'b0;
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (ctl_reset) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.pend = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign step_pend   = q.pend;
    assign cmd_oe      = (q.st == ST_SEND);
    assign cmd_o       = (q.st == ST_SEND) ? q.tx[CMD_BITS-1] : 1'b1;
    assign card_clk_en = (q.st != ST_IDLE);
    assign resp        = q.resp;
    assign crc_ok      = q.crc_ok;
    assign crc_flag    = q.crc_flag;
    assign tout_flag   = q.tout_flag;
    assign dat0_level  = q.dat0;
endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       ctl_reset,
    input logic [4:0] step_pend,
    input logic       cmd_oe,
    input logic       cmd_o,
    input logic       card_clk_en,
    input logic       crc_ok,
    input logic       crc_flag,
    input logic       tout_flag,
    input logic       dat0_i,
    input logic       dat0_level
);
    AST_NO_SPONTANEOUS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ((step_pend & ~$past(step_pend)) == 5'b0)); // R1
    AST_SEND_NEEDS_CMD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> step_pend[0]); // R2
    AST_FLAG_MEANS_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_flag) |-> !crc_ok); // R4
    AST_TOUT_DROPS_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tout_flag) |-> (step_pend[2:1] == 2'b00)); // R5
    AST_LINE_HIGH_OFF_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_o); // R6
    AST_CLOCK_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk_en |-> (step_pend != 5'b0)); // R7
    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |=> (step_pend == 5'b0 && !card_clk_en)); // R8
    AST_DAT0_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dat0_level == $past(dat0_i))); // R9
endmodule

bind sdcmd_engine sdcmd_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ctl_reset   (ctl_reset),
    .step_pend   (step_pend),
    .cmd_oe      (cmd_oe),
    .cmd_o       (cmd_o),
    .card_clk_en (card_clk_en),
    .crc_ok      (crc_ok),
    .crc_flag    (crc_flag),
    .tout_flag   (tout_flag),
    .dat0_i      (dat0_i),
    .dat0_level  (dat0_level)
);

// File: tb/sdcmd_engine_bench.sv
`timescale 1ns/1ps
module sdcmd_engine_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_reset = 1'b0;
    logic         start = 1'b0;
    logic [4:0]   step_en = '0;
    logic [5:0]   cmd_index = '0;
    logic [31:0]  cmd_arg = '0;
    logic         crc_clr = 1'b0;
    logic         tout_clr = 1'b0;
    logic         cmd_i = 1'b1;
    logic         dat0_i = 1'b1;
    logic [4:0]   step_pend;
    logic         cmd_o, cmd_oe, card_clk_en;
    logic [127:0] resp;
    logic         crc_ok, crc_flag, tout_flag, dat0_level;

    int n_checks = 0;
    int n_err = 0;
    int r_clks, r_cyc, r_ntx;
    logic [47:0] r_tx;

    always #2 clk = ~clk;

    sdcmd_engine u_sdcmd_engine (
        .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset), .start(start),
        .step_en(step_en), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .crc_clr(crc_clr), .tout_clr(tout_clr), .cmd_i(cmd_i), .dat0_i(dat0_i),
        .step_pend(step_pend), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
        .card_clk_en(card_clk_en), .resp(resp), .crc_ok(crc_ok),
        .crc_flag(crc_flag), .tout_flag(tout_flag), .dat0_level(dat0_level)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [135:0] act, input logic [135:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // CRC7 over v[n-1] .. v[0], MSB first
    function automatic logic [6:0] bcrc(input logic [135:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb;
            fb = c[6] ^ v[i];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [47:0] cmd_frame(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b01, idx, arg, bcrc({96'b0, 2'b01, idx, arg}, 40), 1'b1};
    endfunction

    function automatic logic [135:0] short_frame(input logic [5:0] idx, input logic [31:0] arg);
        return {88'b0, 2'b00, idx, arg, bcrc({96'b0, 2'b00, idx, arg}, 40), 1'b1};
    endfunction

    function automatic logic [135:0] long_frame(input logic [119:0] body);
        return {2'b00, 6'h3F, body, bcrc({16'b0, body}, 120), 1'b1};
    endfunction

    // launch a step mask and act as the card until every step has cleared
    task automatic run(input logic [4:0] en, input logic [5:0] idx, input logic [31:0] arg,
                       input int dly, input logic [135:0] frm, input int flen);
        int pos = 0;
        bit done = 0;
        r_clks = 0; r_cyc = 0; r_ntx = 0; r_tx = '0;
        @(negedge clk);
        step_en = en; cmd_index = idx; cmd_arg = arg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            if (step_pend == 5'b0) begin
                done = 1;
                break;
            end
            r_cyc++;
            if (card_clk_en) r_clks++;
            if (cmd_oe) begin
                r_tx = {r_tx[46:0], cmd_o};
                r_ntx++;
            end
            if (card_clk_en && !step_pend[0] && !step_pend[3] && (step_pend[1] | step_pend[2])) begin
                if (pos < dly)               cmd_i = 1'b1;
                else if (pos - dly < flen)   cmd_i = frm[flen - 1 - (pos - dly)];
                else                         cmd_i = 1'b1;
                pos++;
            end else begin
                cmd_i = 1'b1;
            end
            @(negedge clk);
        end
        cmd_i = 1'b1;
        check(done, "R7", "steps complete", {135'b0, done}, 136'd1);
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [127:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(step_pend == 0 && !card_clk_en && !cmd_oe && cmd_o, "R1", "reset idle",
              {128'b0, step_pend, card_clk_en, cmd_oe, cmd_o}, 136'h1);
        check(!crc_flag && !tout_flag && resp == 0, "R4", "reset flags",
              {crc_flag, tout_flag, resp}, 136'h0);

        // R9 DAT0 mirror
        dat0_i = 1'b0; @(negedge clk);
        check(dat0_level == 1'b0, "R9", "dat0 low", {135'b0, dat0_level}, 136'd0);
        dat0_i = 1'b1; @(negedge clk);
        check(dat0_level == 1'b1, "R9", "dat0 high", {135'b0, dat0_level}, 136'd1);

        // R2 known CRC7 values
        run(5'b00001, 6'd0, 32'h0, 0, '0, 48);
        check(r_tx[7:1] == 7'h4A, "R2", "crc index0", {129'b0, r_tx[7:1]}, 136'h4A);
        run(5'b00001, 6'd17, 32'h0, 0, '0, 48);
        check(r_tx[7:1] == 7'h2A, "R2", "crc index17", {129'b0, r_tx[7:1]}, 136'h2A);
        run(5'b00001, 6'd8, 32'h1AA, 0, '0, 48);
        check(r_tx[7:1] == 7'h43, "R2", "crc index8", {129'b0, r_tx[7:1]}, 136'h43);

        // sweep every step mask
        for (int e = 0; e < 32; e++) begin
            logic [4:0]   en;
            logic [5:0]   idx;
            logic [31:0]  arg;
            logic [119:0] body;
            logic [135:0] frm;
            logic [127:0] exp_resp;
            int flen, dly, exp_clk, steps;
            bit rsp;
            en   = 5'(e);
            idx  = 6'(e * 7 + 3);
            arg  = 32'h9E37_79B9 * 32'(e + 1);
            body = {arg, ~arg, arg ^ 32'h5A5A_0F0F, arg[23:0]};
            dly  = e % 5;
            rsp  = en[1] | en[2];
            if (en[2]) begin
                frm = long_frame(body); flen = 136; exp_resp = frm[127:0];
            end else begin
                frm = short_frame(idx ^ 6'h15, ~arg); flen = 48;
                exp_resp = {90'b0, idx ^ 6'h15, ~arg};
            end
            exp_clk = 74 * en[3] + 48 * en[0] + (rsp ? dly + flen : 0) + 8 * en[4];
            steps   = en[3] + en[0] + rsp + en[4];
            run(en, idx, arg, dly, frm, flen);
            check(r_clks == exp_clk, "R7", "clock total", 136'(r_clks), 136'(exp_clk));
            check(r_cyc == exp_clk + steps, "R7", "cycle total", 136'(r_cyc), 136'(exp_clk + steps));
            if (en[0]) begin
                check(r_ntx == 48, "R2", "frame length", 136'(r_ntx), 136'd48);
                check(r_tx == cmd_frame(idx, arg), "R2", "frame bits", 136'(r_tx), 136'(cmd_frame(idx, arg)));
            end else begin
                check(r_ntx == 0, "R6", "no drive", 136'(r_ntx), 136'd0);
            end
            if (rsp) begin
                check(resp == exp_resp, "R3", "response", 136'(resp), 136'(exp_resp));
                check(crc_ok && !crc_flag, "R4", "crc good", {134'b0, crc_ok, crc_flag}, 136'h2);
            end
        end

        // R4 bad CRC still flagged and stored
        run(5'b00010, 6'd41, 32'h00FF_8000, 2, short_frame(6'h3F, 32'h80FF_8000) ^ 136'h2, 48);
        check(!crc_ok && crc_flag, "R4", "mismatch", {134'b0, crc_ok, crc_flag}, 136'h1);
        check(resp == {90'b0, 6'h3F, 32'h80FF_8000}, "R4", "stored anyway", 136'(resp),
              {98'b0, 6'h3F, 32'h80FF_8000});
        @(negedge clk); crc_clr = 1'b1;
        @(negedge clk); crc_clr = 1'b0;
        check(!crc_flag, "R4", "flag cleared", {135'b0, crc_flag}, 136'd0);

        // R5 timeout at 64, no timeout at 63
        keep = resp;
        run(5'b00010, 6'd1, 32'h1, 64, short_frame(6'd1, 32'h1), 48);
        check(r_clks == 64, "R5", "timeout clocks", 136'(r_clks), 136'd64);
        check(tout_flag && resp == keep, "R5", "timeout flag", {tout_flag, resp}, {1'b1, keep});
        @(negedge clk); tout_clr = 1'b1;
        @(negedge clk); tout_clr = 1'b0;
        check(!tout_flag, "R5", "flag cleared", {135'b0, tout_flag}, 136'd0);
        run(5'b00010, 6'd2, 32'h2, 63, short_frame(6'd2, 32'h2), 48);
        check(r_clks == 111 && !tout_flag && crc_ok, "R5", "late start",
              {tout_flag, crc_ok, 134'(r_clks)}, {2'b01, 134'd111});

        // R1 start while busy ignored
        @(negedge clk); step_en = 5'b01000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        step_en = 5'b10001; start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(step_pend == 5'b01000, "R1", "busy start", 136'(step_pend), 136'h8);
        begin
            int c = 5;
            for (int k = 0; k < 200 && step_pend != 0; k++) begin
                if (card_clk_en) c++;
                @(negedge clk);
            end
            check(c == 74 && step_pend == 0, "R6", "long burst only", 136'(c), 136'd74);
        end

        // R8 abort
        @(negedge clk); step_en = 5'b11011; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        ctl_reset = 1'b1;
        @(negedge clk); ctl_reset = 1'b0;
        check(step_pend == 0 && !card_clk_en, "R8", "abort", {130'b0, step_pend, card_clk_en}, 136'd0);
        run(5'b10000, 6'd0, 32'h0, 0, '0, 48);
        check(r_clks == 8, "R6", "short burst after abort", 136'(r_clks), 136'd8);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule